// File: doc/BRIEF.md
# Header-Driven Output Port Selector

This unit sits at the input of one switch and chooses the output port for each arriving packet header. It also rewrites the header for the next hop. Each header carries a mode bit that picks one of two mechanisms. In source-routed mode, the header holds a chain of port fields and the unit uses one field per hop. In table-driven mode, the header holds an index into a local route table. The table entry supplies both the output port and the index that the next switch will use.

Headers enter on a valid/ready handshake. A configuration write port loads route-table entries. The chosen port and the rewritten header leave together from a single output register, with a valid signal that stays up until downstream accepts the result. A result appears one clock after its header is accepted. Moving the payload and arbitrating between inputs are left to other logic.

Top module: `hdr_port_sel`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every route-table entry is invalid.
- R2: Source-routed mode is selected by `in_tbl_mode`=0. The port is `in_hdr[PORT_W-1:0]` (bits 2:0 by default). The forwarded header is `in_hdr` shifted right by PORT_W bits, with zeros filled in at the top.
- R3: Table-driven mode is selected by `in_tbl_mode`=1, and the index is `in_hdr[IDX_W-1:0]` (bits 7:0). If the addressed entry is valid, the port is the entry's port and `out_miss` is 0. The forwarded header keeps `in_hdr[HDR_W-1:IDX_W]` and replaces bits 7:0 with the entry's next index.
- R4: A table-driven lookup of an invalid entry sets `out_miss` to 1 and the port to DISCARD (7 by default), and forwards the header unchanged.
- R5: A configuration write is seen by a lookup accepted on the next clock edge or later. A lookup accepted on the same edge as a write to its entry returns the old contents. Writing `cfg_ok`=0 invalidates an entry.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_port`, `out_hdr` and `out_miss` hold their values.
- R7: `in_ready` is 1 whenever the output register is empty or is being drained. A header accepted on a clock edge is presented on `out_valid` after that edge. Results leave in the order their headers were accepted.
- R8: In source-routed mode, `out_miss` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Header can be accepted |
| in_tbl_mode | input | 1 | 1 = table-driven, 0 = source-routed |
| in_hdr | input | HDR_W | Incoming header |
| cfg_we | input | 1 | Route-table write strobe |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_ok | input | 1 | Valid bit written to the entry |
| cfg_port | input | PORT_W | Output port stored in the entry |
| cfg_next | input | IDX_W | Next-hop index stored in the entry |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_port | output | PORT_W | Selected output port |
| out_hdr | output | HDR_W | Rewritten header |
| out_miss | output | 1 | Lookup hit an invalid entry |

## Verification
The hardest case to reach is a table write and a lookup of the same entry on the same edge. The stimulus gets there by first draining the output register with `out_ready` held high. It then drives the write strobe and the header in one cycle, expects the old entry, and follows at once with a second lookup that must see the new entry. Holding stability is reached by throttling `out_ready` to one cycle in three while headers stream in back to back.

// File: rtl/hdr_port_sel.sv
module hdr_port_sel #(
  parameter int HDR_W   = 32,
  parameter int PORT_W  = 3,
  parameter int IDX_W   = 8,
  parameter int DISCARD = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_tbl_mode,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_ok,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [IDX_W-1:0]  cfg_next,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PORT_W-1:0] out_port,
  output logic [HDR_W-1:0]  out_hdr,
  output logic              out_miss
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [PORT_W-1:0] DISC = DISCARD[PORT_W-1:0];

  logic [DEPTH-1:0]  vld_q;
  logic [PORT_W-1:0] port_mem [DEPTH];
  logic [IDX_W-1:0]  next_mem [DEPTH];

  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              take;
  logic [PORT_W-1:0] nx_port;
  logic [HDR_W-1:0]  nx_hdr;
  logic              nx_miss;

  assign idx      = in_hdr[IDX_W-1:0];
  assign hit      = vld_q[idx];
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    if (!in_tbl_mode) begin
      nx_port = in_hdr[PORT_W-1:0];
      nx_hdr  = in_hdr >> PORT_W;
      nx_miss = 1'b0;
    end else if (hit) begin
      nx_port = port_mem[idx];
      nx_hdr  = {in_hdr[HDR_W-1:IDX_W], next_mem[idx]};
      nx_miss = 1'b0;
    end else begin
      nx_port = DISC;
      nx_hdr  = in_hdr;
      nx_miss = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (cfg_we) vld_q[cfg_idx] <= cfg_ok;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      port_mem[cfg_idx] <= cfg_port;
      next_mem[cfg_idx] <= cfg_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_hdr   <= '0;
      out_miss  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_port  <= nx_port;
      out_hdr   <= nx_hdr;
      out_miss  <= nx_miss;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_port_sel_chk.sv
module hdr_port_sel_chk #(
  parameter int HDR_W   = 32,
  parameter int PORT_W  = 3,
  parameter int DISCARD = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_tbl_mode,
  input logic [HDR_W-1:0]  in_hdr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PORT_W-1:0] out_port,
  input logic [HDR_W-1:0]  out_hdr,
  input logic              out_miss
);
  // R2 R8
  src_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_tbl_mode |=>
      out_port == $past(in_hdr[PORT_W-1:0]) && out_hdr == ($past(in_hdr) >> PORT_W) && !out_miss);

  // R4
  miss_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_miss |-> out_port == DISCARD[PORT_W-1:0]);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_port) && $stable(out_hdr) && $stable(out_miss));

  // R7
  accept_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

bind hdr_port_sel hdr_port_sel_chk #(.HDR_W(HDR_W), .PORT_W(PORT_W), .DISCARD(DISCARD)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_tbl_mode(in_tbl_mode), .in_hdr(in_hdr), .out_valid(out_valid),
  .out_ready(out_ready), .out_port(out_port), .out_hdr(out_hdr), .out_miss(out_miss));

// File: tb/sim_hdr_port_sel.sv
module sim_hdr_port_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_tbl_mode = 1'b0;
  logic [31:0] in_hdr = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_idx = '0;
  logic        cfg_ok = 1'b0;
  logic [2:0]  cfg_port = '0;
  logic [7:0]  cfg_next = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_port;
  logic [31:0] out_hdr;
  logic        out_miss;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;
  int cyc = 0;

  bit       m_vld [256];
  bit [2:0] m_port [256];
  bit [7:0] m_next [256];
  logic [35:0] exp_q [$];

  always #10 clk = ~clk;

  hdr_port_sel u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tbl_mode(in_tbl_mode), .in_hdr(in_hdr), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_ok(cfg_ok), .cfg_port(cfg_port), .cfg_next(cfg_next), .out_valid(out_valid),
    .out_ready(out_ready), .out_port(out_port), .out_hdr(out_hdr), .out_miss(out_miss));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] model(input bit tm, input logic [31:0] h);
    if (!tm) return {1'b0, h[2:0], 32'(h >> 3)};
    if (m_vld[h[7:0]]) return {1'b0, m_port[h[7:0]], h[31:8], m_next[h[7:0]]};
    return {1'b1, 3'd7, h};
  endfunction

  task automatic send(input bit tm, input logic [31:0] h);
    @(negedge clk);
    in_valid = 1'b1; in_tbl_mode = tm; in_hdr = h;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    exp_q.push_back(model(tm, h));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] i, input bit ok, input logic [2:0] p, input logic [7:0] n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_ok = ok; cfg_port = p; cfg_next = n;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    m_vld[i] = ok; m_port[i] = p; m_next[i] = n;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: out_ready is set at each negedge and held to the next posedge.
  logic        held = 1'b0;
  logic [35:0] held_v;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (held) check("R6 hold", {out_valid, out_miss, out_port, out_hdr}, {1'b1, held_v});
      out_ready = bp_on ? (cyc % 3 == 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R7 unexpected output", 64'(out_hdr), 64'hDEAD);
        else check("R2/R3/R4/R8 result", {out_miss, out_port, out_hdr}, exp_q.pop_front());
      end
      held = out_valid && !out_ready;
      held_v = {out_miss, out_port, out_hdr};
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_vld[i] = 0; m_port[i] = 0; m_next[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
    // R1 table starts invalid -> R4 discard
    send(1'b1, 32'hCAFE_0005);
    send(1'b1, 32'h0000_00FF);
    // R2 R8 source routing
    send(1'b0, 32'h1234_5677);
    send(1'b0, 32'hFFFF_FFFF);
    send(1'b0, 32'h0000_0003);
    drain();
    // R3 hits, R5 next-cycle visibility
    cfg_write(8'h05, 1'b1, 3'd2, 8'hA1);
    send(1'b1, 32'hCAFE_0005);
    cfg_write(8'hFF, 1'b1, 3'd6, 8'h00);
    cfg_write(8'h00, 1'b1, 3'd1, 8'hFF);
    send(1'b1, 32'h8000_00FF);
    send(1'b1, 32'h0123_4500);
    // R4 invalidate
    cfg_write(8'hFF, 1'b0, 3'd3, 8'h11);
    send(1'b1, 32'h8000_00FF);
    drain();
    // R5 same-edge write and lookup returns old contents
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 8'h05; cfg_ok = 1'b1; cfg_port = 3'd4; cfg_next = 8'h3C;
    in_valid = 1'b1; in_tbl_mode = 1'b1; in_hdr = 32'h7777_0005;
    #2 check("R5 in_ready before same-edge", 64'(in_ready), 64'd1);
    exp_q.push_back(model(1'b1, 32'h7777_0005));
    @(posedge clk);
    #1 cfg_we = 1'b0; in_valid = 1'b0;
    m_vld[5] = 1; m_port[5] = 3'd4; m_next[5] = 8'h3C;
    send(1'b1, 32'h7777_0005);
    drain();
    // R6 R7 backpressure with back-to-back mixed traffic
    bp_on = 1'b1;
    for (int k = 0; k < 24; k++)
      send(k[0], {k[7:0], 8'h5A, 8'h00, (k % 3 == 0) ? 8'h05 : 8'h00} ^ 32'(k * 8));
    drain();
    bp_on = 1'b0;
    drain();
    check("R7 queue empty", 64'(exp_q.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule